// File: doc/BRIEF.md
# Management-Port PHY Register Model

This block is a register-mapped management master with a small emulated transceiver register file behind it. A host reaches four 32-bit registers over a simple write strobe and address bus, and reads them back through a combinational data mux. The four registers are a control word, a command word, a write-data word and a read-data word. The control word turns management on and sets a clock divider. A command word with its initiate bit set runs one transaction against the emulated transceiver. The transaction either stores the write-data value into a transceiver register or captures a transceiver register into the read-data word.

The emulated transceiver answers only at one 5-bit address, set by a parameter. It holds a writable basic-control register and a writable advertisement register. It also has fixed status and identifier values, and a partner-ability register that copies the local advertisement. A diagnostic register shows the speed and duplex that the advertised modes imply. Serial clock and data timing on the wire are not modelled. Instead, a ready output drops for a fixed number of divider-scaled cycles after each accepted transaction.

Top module: `mdio_mgmt_model`

## Requirements
- R1: The control register (bus address 0) keeps only bits 6:0 and reads zero above them. Bit 6 enables management and bits 5:0 hold the divider. `cfg_err` is high while bit 6 is set and the divider is zero.
- R2: Reading the command register (bus address 1) returns the last written command word with bit 7 forced to one.
- R3: After reset, transceiver register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400 and register 4 reads 0x01E1.
- R4: Transceiver register 1 always reads 0x782E. This is bits 14:11, 5, 3, 2 and 1 set.
- R5: Transceiver register 5 reads 0x4000 ORed with bits 8:5 of register 4.
- R6: A write to transceiver register 0 stores the value with bit 15 cleared.
- R7: Diagnostic register DIAG_REG (default 18) sets bit 10 when register 4 bit 7 or bit 8 is set. It sets bit 11 when register 4 bit 8 or bit 6 is set. All its other bits are zero.
- R8: A transaction to any transceiver address other than PHY_ADDR (default 7) reads back zero and changes no register.
- R9: The command word holds the transceiver address in bits 28:24, the register in bits 20:16, the opcode in bits 15:14 and initiate in bit 11. Opcode 1 writes the write-data register (bus address 2) to the transceiver. Opcode 2 loads the read-data register (bus address 3). Any other opcode with initiate set pulses `op_err` for one cycle, performs no access, leaves read-data unchanged and keeps `mdio_ready` high.
- R10: A valid initiated command drops `mdio_ready` for FRAME_BITS × max(divider,1) cycles, starting at its write edge. A command issued while `mdio_ready` is low does nothing.
- R11: The write-data register keeps bits 15:0 only. A command write with bit 11 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 command, 2 write data, 3 read data |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register read value for `reg_addr` |
| mdio_ready | output | 1 | High when no transaction is in progress |
| cfg_err | output | 1 | Management enabled with a zero divider |
| op_err | output | 1 | One-cycle pulse on an initiated command with an invalid opcode |

## Verification
Transceiver reads are run first against reset contents. They are repeated after the advertisement register is set to different mode subsets: 10-full only, then 100-half only. This separates the partner-ability mirror from the speed bit and the duplex bit of the diagnostic register. Misaddressed reads and writes, invalid opcodes and commands without initiate each show a distinct form of "no effect" at the ports. A command issued while a read is still in progress checks that busy time really blocks a second access. Counting the ready-low cycles at divider 3 separates a correctly scaled frame time from an unscaled one.

// File: rtl/mdio_mgmt_model.sv
module mdio_mgmt_model #(
  parameter int PHY_ADDR   = 7,
  parameter int FRAME_BITS = 32,
  parameter int DIAG_REG   = 18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdio_ready,
  output logic        cfg_err,
  output logic        op_err
);
  localparam int CNT_W = $clog2(FRAME_BITS * 63 + 1);
  localparam logic [4:0] MY_ADDR = PHY_ADDR[4:0];
  localparam logic [4:0] DIAG    = DIAG_REG[4:0];

  logic [6:0]       ctrl_q;
  logic [31:0]      cmd_q;
  logic [15:0]      wd_q, rd_q, bmcr_q, adv_q, phy_q;
  logic [CNT_W-1:0] busy_q;

  wire       cmd_wr = reg_wr && reg_addr == 2'd1;
  wire [4:0] c_phy  = reg_wdata[28:24];
  wire [4:0] c_reg  = reg_wdata[20:16];
  wire [1:0] c_op   = reg_wdata[15:14];
  wire       c_go   = reg_wdata[11];
  wire       accept = cmd_wr && c_go && mdio_ready;
  wire       op_ok  = c_op == 2'd1 || c_op == 2'd2;
  wire       hit    = c_phy == MY_ADDR;
  wire [5:0] div_eff = (ctrl_q[5:0] == 6'd0) ? 6'd1 : ctrl_q[5:0];

  assign mdio_ready = busy_q == '0;
  assign cfg_err    = ctrl_q[6] && ctrl_q[5:0] == 6'd0;

  always_comb begin
    case (c_reg)
      5'd0:    phy_q = bmcr_q;
      5'd1:    phy_q = 16'h782E;
      5'd2:    phy_q = 16'h0300;
      5'd3:    phy_q = 16'hE400;
      5'd4:    phy_q = adv_q;
      5'd5:    phy_q = 16'h4000 | {7'd0, adv_q[8:5], 5'd0};
      default: phy_q = (c_reg == DIAG) ?
                       {4'd0, adv_q[8] | adv_q[6], adv_q[8] | adv_q[7], 10'd0} : 16'd0;
    endcase
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {25'd0, ctrl_q};
      2'd1:    reg_rdata = cmd_q | 32'h0000_0080;
      2'd2:    reg_rdata = {16'd0, wd_q};
      default: reg_rdata = {16'd0, rd_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmd_q  <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      bmcr_q <= 16'h3100;
      adv_q  <= 16'h01E1;
      busy_q <= '0;
      op_err <= 1'b0;
    end else begin
      op_err <= accept && !op_ok;
      if (reg_wr) begin
        case (reg_addr)
          2'd0:    ctrl_q <= reg_wdata[6:0];
          2'd1:    cmd_q  <= reg_wdata;
          2'd2:    wd_q   <= reg_wdata[15:0];
          default: ;
        endcase
      end
      if (accept && c_op == 2'd1 && hit) begin
        if (c_reg == 5'd0) bmcr_q <= wd_q & 16'h7FFF;
        if (c_reg == 5'd4) adv_q  <= wd_q;
      end
      if (accept && c_op == 2'd2)
        rd_q <= hit ? phy_q : 16'd0;
      if (accept && op_ok)
        busy_q <= CNT_W'(FRAME_BITS) * CNT_W'(div_eff);
      else if (busy_q != '0)
        busy_q <= busy_q - 1'b1;
    end
  end
endmodule

// File: rtl/mdio_mgmt_model_chk.sv
module mdio_mgmt_model_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        mdio_ready,
  input logic        cfg_err,
  input logic        op_err
);
  wire go_cmd = reg_wr && reg_addr == 2'd1 && reg_wdata[11];
  wire op_ok  = reg_wdata[15:14] == 2'd1 || reg_wdata[15:14] == 2'd2;

  // R10
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_cmd && op_ok && mdio_ready) |=> !mdio_ready);
  // R10
  stay_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_ready && !(go_cmd && op_ok)) |=> mdio_ready);
  // R9
  op_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_err) |-> $past(go_cmd && !op_ok && mdio_ready));
  // R9
  op_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |=> (!op_err || $past(go_cmd)));
  // R2
  cmd_ready_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 2'd1 |-> reg_rdata[7]);
  // R1
  ctrl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 2'd0 |-> reg_rdata[31:7] == 25'd0);
  // R11
  wd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 2'd2 |-> reg_rdata[31:16] == 16'd0);
endmodule

bind mdio_mgmt_model mdio_mgmt_model_chk u_chk (.*);

// File: tb/mdio_mgmt_model_tb.sv
module mdio_mgmt_model_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        mdio_ready, cfg_err, op_err;
  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  mdio_mgmt_model u_dut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    if (exp_q.size() != 0) check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic expect_rd(logic [1:0] a, logic [31:0] e, string tag);
    @(posedge clk); #1;
    reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); #1;
  endtask

  function automatic logic [31:0] mk(logic [1:0] op, logic [4:0] phy, logic [4:0] r, logic go);
    return {3'd0, phy, 3'd0, r, op, 2'd0, go, 11'd0};
  endfunction

  task automatic wait_ready();
    @(negedge clk);
    while (!mdio_ready) @(negedge clk);
  endtask

  task automatic phy_rd(logic [4:0] phy, logic [4:0] r, logic [15:0] e, string tag);
    wr(2'd1, mk(2'd2, phy, r, 1'b1));
    wait_ready();
    expect_rd(2'd3, {16'd0, e}, tag);
  endtask

  task automatic phy_wr(logic [4:0] phy, logic [4:0] r, logic [15:0] d);
    wr(2'd2, {16'd0, d});
    wr(2'd1, mk(2'd1, phy, r, 1'b1));
    wait_ready();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R10 reset ready", mdio_ready, 1);
    check("R9 reset op_err", op_err, 0);
    expect_rd(2'd0, 0, "R1 reset ctrl");
    expect_rd(2'd3, 0, "R9 reset rdata");

    phy_rd(7, 0, 16'h3100, "R3 reg0");
    phy_rd(7, 2, 16'h0300, "R3 reg2");
    phy_rd(7, 3, 16'hE400, "R3 reg3");
    phy_rd(7, 4, 16'h01E1, "R3 reg4");
    phy_rd(7, 1, 16'h782E, "R4 status");
    phy_rd(7, 5, 16'h41E0, "R5 partner default");
    phy_rd(7, 18, 16'h0C00, "R7 diag default");

    phy_wr(7, 4, 16'h0041);
    phy_rd(7, 5, 16'h4040, "R5 partner 10full");
    phy_rd(7, 18, 16'h0800, "R7 diag 10full");
    phy_wr(7, 4, 16'h0081);
    phy_rd(7, 5, 16'h4080, "R5 partner 100half");
    phy_rd(7, 18, 16'h0400, "R7 diag 100half");

    phy_wr(7, 0, 16'h9200);
    phy_rd(7, 0, 16'h1200, "R6 reset bit self-clear");

    phy_rd(3, 2, 16'h0000, "R8 absent phy read");
    phy_wr(3, 4, 16'h0001);
    phy_rd(7, 4, 16'h0081, "R8 absent phy write ignored");

    wr(2'd2, 32'h0000_0021);
    wr(2'd1, mk(2'd0, 7, 4, 1'b1));
    @(negedge clk);
    check("R9 op_err pulse", op_err, 1);
    check("R9 ready kept", mdio_ready, 1);
    @(negedge clk);
    check("R9 op_err one cycle", op_err, 0);
    expect_rd(2'd3, 32'h0081, "R9 rdata unchanged");
    phy_rd(7, 4, 16'h0081, "R9 no write on bad op");

    wr(2'd0, 32'h0000_0040);
    @(negedge clk);
    check("R1 cfg_err zero divider", cfg_err, 1);
    wr(2'd0, 32'hFFFF_FFC3);
    @(negedge clk);
    check("R1 cfg_err cleared", cfg_err, 0);
    expect_rd(2'd0, 32'h43, "R1 ctrl low bits");

    wr(2'd1, 32'h0304_0001);
    expect_rd(2'd1, 32'h0304_0081, "R2 cmd readback");
    wr(2'd2, 32'hABCD_1234);
    expect_rd(2'd2, 32'h1234, "R11 wdata width");
    wr(2'd1, mk(2'd1, 7, 4, 1'b0));
    @(negedge clk);
    check("R11 no initiate ready", mdio_ready, 1);
    phy_rd(7, 4, 16'h0081, "R11 no initiate no write");

    wr(2'd1, mk(2'd2, 7, 1, 1'b1));
    n = 0;
    @(negedge clk);
    while (!mdio_ready && n < 1000) begin n++; @(negedge clk); end
    check("R10 busy cycles div3", n, 96);

    wr(2'd2, 32'h0000_0061);
    wr(2'd1, mk(2'd2, 7, 2, 1'b1));
    wr(2'd1, mk(2'd1, 7, 4, 1'b1));
    wait_ready();
    expect_rd(2'd3, 32'h0300, "R10 first command result");
    phy_rd(7, 4, 16'h0081, "R10 command while busy ignored");

    repeat (2) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule